// File: doc/BRIEF.md
# Auto-Reload Wake-Up Timer

A 16-bit up-counter with a 16-bit reload value. Each time the count passes 0xFFFF it loads the reload value, so the overflow period is set by software. The counter steps once per timer tick. A select input picks the tick source:

- every system clock,
- every twelfth system clock,
- every eighth rising edge of an external slow clock,
- every eighth rising edge of a low-frequency oscillator clock.

A byte-wide register port gives access to the count, the reload value and a control byte. The control byte holds the overflow flags and the interrupt enables.

The block also covers the low-power suspend state. While `suspend` is high, the system-clock sources stop. The slow clocks then bypass their synchronizers and step the counter directly. An overflow in this state pulses `wake`.

Suspend can also end for another reason, with no timer overflow. In that case `busy` rises and stays high for three timer ticks. While it is high, count writes are dropped and count reads return the last value captured before the window opened.

Top module: `reload_wake_timer`

## Requirements
- R1: After reset, every readable register reads 0x00, and `irq`, `wake` and `busy` are low.
- R2: The register addresses are as follows.
  - 0: count bits 7:0
  - 1: count bits 15:8
  - 2: reload bits 7:0
  - 3: reload bits 15:8
  - 4: control byte, with bit0 the wrap flag, bit1 the low-byte flag, bit2 the low-byte interrupt enable, bit3 the interrupt enable and bit4 `busy` (read-only).
  - A written byte reads back unchanged, except for the flag bits and except when a count write is dropped under R11.
  - Reads are combinational.
- R3: While `run_en` is high, the count rises by exactly one on each selected tick. While `run_en` is low, the count holds.
- R4: A tick at count 0xFFFF loads the reload value into the count and sets the wrap flag.
- R5: A tick at a count whose low byte is 0xFF sets the low-byte flag, but only when both interrupt enables are set.
- R6: The flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it as it was.
- R7: `irq` = interrupt enable AND (wrap flag OR (low-byte enable AND low-byte flag)).
- R8: The meaning of `src_sel` is as follows.
  - 0: every system clock
  - 1: exactly one tick per 12 system clocks
  - 2: one tick per 8 rising edges of `ext_clk`
  - 3: one tick per 8 rising edges of `lfo_clk`
  - The slow clock that is not selected has no effect on the count.
- R9: While `suspend` is high, sources 0 and 1 give no ticks. A wrap during suspend pulses `wake` high for one cycle. A wrap outside suspend never raises `wake`.
- R10: A fall of `suspend` with no timer wake during that suspend raises `busy`. `busy` clears on the third following tick of the selected source. A fall that follows a timer wake leaves `busy` low.
- R11: While `busy` is high, writes to addresses 0 and 1 are ignored, and count reads return the count captured just before `busy` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counter run enable |
| src_sel | input | 2 | Tick source select (R8 encoding) |
| suspend | input | 1 | Low-power suspend state |
| ext_clk | input | 1 | External slow clock |
| lfo_clk | input | 1 | Low-frequency oscillator clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | One-cycle wake pulse on wrap during suspend |
| busy | output | 1 | Register access unsafe after a foreign wake |

## Verification
The bench targets the following corner cases.

- **Wrap:** the bench wraps from 0xFFFE through 0xFFFF into a non-zero reload. A design that resets the count to zero, or that misses the flag, shows up right away.
- **Low-byte flag:** the bench crosses a low-byte boundary once with the low-byte enable clear and once with it set. This catches a flag that ignores its enables.
- **Divided sources:** the bench counts ticks over exactly 120 system clocks and over exactly 16 slow edges. An off-by-one divider shows up as a wrong final count. Edges on the unselected slow clock are also driven, to catch crossed source wiring.
- **Suspend:** the bench ends suspend both through a timer wake and without one. A design that sets `busy` after its own wake, never clears it, or still accepts count writes during the window fails the readback.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

    typedef enum logic [1:0] {
        SRC_SYS    = 2'd0,
        SRC_SYS12  = 2'd1,
        SRC_EXT8   = 2'd2,
        SRC_LFO8   = 2'd3
    } tick_src_e;

    typedef enum logic [2:0] {
        RA_CNT_LO = 3'd0,
        RA_CNT_HI = 3'd1,
        RA_RLD_LO = 3'd2,
        RA_RLD_HI = 3'd3,
        RA_CTRL   = 3'd4
    } reg_addr_e;

    // control byte bit positions
    localparam int CB_FLAG_HI = 0;
    localparam int CB_FLAG_LO = 1;
    localparam int CB_LO_EN   = 2;
    localparam int CB_IRQ_EN  = 3;
    localparam int CB_BUSY    = 4;

endpackage

// File: rtl/rwt_tick_div.sv
// Free-running divider: one output pulse every DIV input steps.
module rwt_tick_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (step) begin
            if (st_q.cnt == W'(DIV - 1)) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rwt_slow_edge.sv
// Rising-edge pulse for a slow clock: synchronized normally, raw when bypassed.
module rwt_slow_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_in,
    input  logic bypass,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              sync_prev;
        logic              raw_prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sync      = {st_q.sync[STAGES-2:0], slow_in};
        st_d.sync_prev = st_q.sync[STAGES-1];
        st_d.raw_prev  = slow_in;
        if (bypass) pulse_o = slow_in & ~st_q.raw_prev;
        else        pulse_o = st_q.sync[STAGES-1] & ~st_q.sync_prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/reload_wake_timer.sv
module reload_wake_timer
    import rwt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYS_DIV     = 12,
    parameter int SLOW_DIV    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_TICKS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        src_sel,
    input  logic              suspend,
    input  logic              ext_clk,
    input  logic              lfo_clk,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              wake,
    output logic              busy
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int BC_W  = $clog2(BUSY_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] shadow;
        logic             flag_hi;
        logic             flag_lo;
        logic             lo_en;
        logic             irq_en;
        logic             busy;
        logic [BC_W-1:0]  busy_cnt;
        logic             woke;
        logic             susp;
        logic             wake;
    } state_t;

    state_t st_d, st_q;

    // ---------------- tick sources ----------------
    logic       tick12;
    logic [1:0] slow_raw;
    logic [1:0] slow_tick;
    logic       src_tick;

    assign slow_raw = {lfo_clk, ext_clk};

    rwt_tick_div #(.DIV(SYS_DIV)) u_sysdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .step (1'b1),
        .tick (tick12)
    );

    for (genvar k = 0; k < 2; k++) begin : g_slow
        logic pulse;
        rwt_slow_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .slow_in(slow_raw[k]),
            .bypass (suspend),
            .pulse_o(pulse)
        );
        rwt_tick_div #(.DIV(SLOW_DIV)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .step (pulse),
            .tick (slow_tick[k])
        );
    end

    always_comb begin
        case (tick_src_e'(src_sel))
            SRC_SYS:   src_tick = ~suspend;
            SRC_SYS12: src_tick = tick12 & ~suspend;
            SRC_EXT8:  src_tick = slow_tick[0];
            default:   src_tick = slow_tick[1];
        endcase
    end

    // ---------------- next state ----------------
    logic cnt_wr;
    logic cnt_wr_ok;
    logic step;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        st_d.susp = suspend;
        cnt_wr    = wr_en && (addr == RA_CNT_LO || addr == RA_CNT_HI);
        cnt_wr_ok = cnt_wr && !st_q.busy;
        step      = src_tick && run_en;

        // register writes
        if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_CNT_LO: if (!st_q.busy) st_d.count[BYTE_W-1:0]      = wdata;
                RA_CNT_HI: if (!st_q.busy) st_d.count[CNT_W-1:BYTE_W]  = wdata;
                RA_RLD_LO: st_d.reload[BYTE_W-1:0]     = wdata;
                RA_RLD_HI: st_d.reload[CNT_W-1:BYTE_W] = wdata;
                RA_CTRL: begin
                    st_d.flag_hi = st_q.flag_hi & wdata[CB_FLAG_HI];
                    st_d.flag_lo = st_q.flag_lo & wdata[CB_FLAG_LO];
                    st_d.lo_en   = wdata[CB_LO_EN];
                    st_d.irq_en  = wdata[CB_IRQ_EN];
                end
                default: ;
            endcase
        end

        // counting; a same-cycle accepted count write takes the cycle
        if (step && !cnt_wr_ok) begin
            if (st_q.count == '1) begin
                st_d.count   = st_q.reload;
                st_d.flag_hi = 1'b1;
                st_d.wake    = suspend;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
            if (st_q.count[BYTE_W-1:0] == '1 && st_q.irq_en && st_q.lo_en)
                st_d.flag_lo = 1'b1;
        end

        // suspend bookkeeping and access guard
        if (suspend && !st_q.susp) st_d.woke = 1'b0;
        if (st_d.wake)             st_d.woke = 1'b1;

        if (!suspend && st_q.susp && !st_q.woke) begin
            st_d.busy     = 1'b1;
            st_d.busy_cnt = '0;
        end else if (st_q.busy && src_tick) begin
            if (st_q.busy_cnt == BC_W'(BUSY_TICKS - 1)) begin
                st_d.busy     = 1'b0;
                st_d.busy_cnt = '0;
            end else begin
                st_d.busy_cnt = st_q.busy_cnt + 1'b1;
            end
        end

        st_d.shadow = st_q.busy ? st_q.shadow : st_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    logic [CNT_W-1:0] view;
    logic [CNT_W-1:0] cur_count;
    logic [CNT_W-1:0] cur_reload;
    logic             cur_flag_hi;
    logic             cur_irq_en;

    assign view        = st_q.busy ? st_q.shadow : st_q.count;
    assign cur_count   = st_q.count;
    assign cur_reload  = st_q.reload;
    assign cur_flag_hi = st_q.flag_hi;
    assign cur_irq_en  = st_q.irq_en;

    assign irq  = st_q.irq_en & (st_q.flag_hi | (st_q.lo_en & st_q.flag_lo));
    assign wake = st_q.wake;
    assign busy = st_q.busy;

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_CNT_LO: rdata = view[BYTE_W-1:0];
            RA_CNT_HI: rdata = view[CNT_W-1:BYTE_W];
            RA_RLD_LO: rdata = st_q.reload[BYTE_W-1:0];
            RA_RLD_HI: rdata = st_q.reload[CNT_W-1:BYTE_W];
            RA_CTRL: begin
                rdata[CB_FLAG_HI] = st_q.flag_hi;
                rdata[CB_FLAG_LO] = st_q.flag_lo;
                rdata[CB_LO_EN]   = st_q.lo_en;
                rdata[CB_IRQ_EN]  = st_q.irq_en;
                rdata[CB_BUSY]    = st_q.busy;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/rwt_checker.sv
module rwt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             suspend,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic             irq,
    input logic             wake,
    input logic             busy,
    input logic             src_tick,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] cur_reload,
    input logic             cur_flag_hi,
    input logic             cur_irq_en
);
    logic cnt_addr;
    assign cnt_addr = (addr <= 3'd1);

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_tick && run_en && cur_count == '1 && !(wr_en && cnt_addr)) |=> cur_count == $past(cur_reload)); // R4

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(cur_count)); // R3

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_irq_en |-> !irq); // R7

    AST_WAKE_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(suspend)); // R9

    AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && cnt_addr && !(src_tick && run_en)) |=> $stable(cur_count)); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_flag_hi && !(wr_en && addr == 3'd4)) |=> cur_flag_hi); // R6
endmodule

bind reload_wake_timer rwt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .suspend    (suspend),
    .wr_en      (wr_en),
    .addr       (addr),
    .irq        (irq),
    .wake       (wake),
    .busy       (busy),
    .src_tick   (src_tick),
    .cur_count  (cur_count),
    .cur_reload (cur_reload),
    .cur_flag_hi(cur_flag_hi),
    .cur_irq_en (cur_irq_en)
);

// File: tb/reload_wake_timer_test.sv
`timescale 1ns/1ps
module reload_wake_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       suspend = 1'b0;
    logic       ext_clk = 1'b0;
    logic       lfo_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, wake, busy;

    int checks = 0;
    int fails  = 0;
    int wake_seen = 0;
    bit done = 1'b0;

    reload_wake_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
        .suspend(suspend), .ext_clk(ext_clk), .lfo_clk(lfo_clk),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .wake(wake), .busy(busy)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (rst_n && wake) wake_seen++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_count(output logic [15:0] v);
        logic [7:0] lo, hi;
        reg_rd(3'd0, lo);
        reg_rd(3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set_count(input logic [15:0] v);
        reg_wr(3'd0, v[7:0]);
        reg_wr(3'd1, v[15:8]);
    endtask

    task automatic run_cycles(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic slow_edges(input bit use_lfo, input int n);
        for (int i = 0; i < n; i++) begin
            if (use_lfo) lfo_clk = 1'b1; else ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            if (use_lfo) lfo_clk = 1'b0; else ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 5; a++) begin
            reg_rd(a[2:0], d);
            chk("R1", "reset register", d, 8'h00);
        end
        chk("R1", "reset irq/wake/busy", {irq, wake, busy}, 3'b000);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        logic [7:0] d;
        src_sel = 2'd0;
        reg_wr(3'd2, 8'h34);
        reg_wr(3'd3, 8'h12);
        reg_rd(3'd2, d); chk("R2", "reload lo readback", d, 8'h34);
        reg_rd(3'd3, d); chk("R2", "reload hi readback", d, 8'h12);
        set_count(16'hFFFE);
        rd_count(v); chk("R2", "count readback", v, 16'hFFFE);
        wake_seen = 0;
        run_cycles(2);
        rd_count(v); chk("R4", "count after wrap", v, 16'h1234);
        reg_rd(3'd4, d); chk("R4", "wrap flag set", d[0], 1'b1);
        chk("R7", "irq off without enable", irq, 1'b0);
        chk("R9", "no wake outside suspend", wake_seen, 0);
        run_cycles(3);
        rd_count(v); chk("R3", "three ticks after wrap", v, 16'h1237);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        reg_wr(3'd4, 8'h09);
        chk("R7", "irq with enable and wrap flag", irq, 1'b1);
        reg_rd(3'd4, d); chk("R6", "write 1 keeps flag", d[0], 1'b1);
        reg_wr(3'd4, 8'h08);
        reg_rd(3'd4, d); chk("R6", "write 0 clears flag", d[0], 1'b0);
        chk("R7", "irq drops after clear", irq, 1'b0);
    endtask

    task automatic t_low;
        logic [15:0] v;
        logic [7:0] d;
        reg_wr(3'd4, 8'h08);
        set_count(16'h00FF);
        run_cycles(1);
        rd_count(v); chk("R3", "low byte carry", v, 16'h0100);
        reg_rd(3'd4, d); chk("R5", "no low flag without low enable", d[1], 1'b0);
        chk("R7", "irq stays low", irq, 1'b0);
        reg_wr(3'd4, 8'h0C);
        set_count(16'h01FF);
        run_cycles(1);
        reg_rd(3'd4, d); chk("R5", "low flag with both enables", d[1:0], 2'b10);
        chk("R7", "irq from low flag", irq, 1'b1);
        reg_wr(3'd4, 8'h0C);
        chk("R6", "low flag cleared by write 0", irq, 1'b0);
        reg_wr(3'd4, 8'h00);
    endtask

    task automatic t_hold;
        logic [15:0] v;
        set_count(16'h0777);
        repeat (8) @(negedge clk);
        rd_count(v); chk("R3", "hold with run_en low", v, 16'h0777);
    endtask

    task automatic t_div12;
        logic [15:0] v;
        src_sel = 2'd1;
        set_count(16'h0000);
        run_cycles(120);
        rd_count(v); chk("R8", "sysclk/12 over 120 cycles", v, 16'd10);
    endtask

    task automatic t_slow;
        logic [15:0] v;
        src_sel = 2'd2;
        set_count(16'h0000);
        @(negedge clk); run_en = 1'b1;
        slow_edges(1'b0, 16);
        repeat (6) @(negedge clk);
        run_en = 1'b0;
        rd_count(v); chk("R8", "ext over 16 edges", v, 16'd2);
        @(negedge clk); run_en = 1'b1;
        slow_edges(1'b1, 16);
        repeat (6) @(negedge clk);
        run_en = 1'b0;
        rd_count(v); chk("R8", "lfo ignored when ext selected", v, 16'd2);
    endtask

    task automatic t_suspend_wake;
        logic [15:0] v;
        src_sel = 2'd3;
        reg_wr(3'd2, 8'h00);
        reg_wr(3'd3, 8'h40);
        set_count(16'hFFFE);
        wake_seen = 0;
        @(negedge clk); suspend = 1'b1; run_en = 1'b1;
        slow_edges(1'b1, 16);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        chk("R9", "one wake pulse in suspend", wake_seen, 1);
        rd_count(v); chk("R4", "reload after suspend wrap", v, 16'h4000);
        suspend = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "no busy after timer wake", busy, 1'b0);
        // system-clock source is silent during suspend
        src_sel = 2'd0;
        suspend = 1'b1;
        run_cycles(10);
        rd_count(v); chk("R9", "sysclk source stopped in suspend", v, 16'h4000);
        suspend = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_busy;
        logic [15:0] v;
        logic [7:0] d;
        src_sel = 2'd1;
        set_count(16'h0AAA);
        @(negedge clk); suspend = 1'b1;
        repeat (3) @(negedge clk);
        suspend = 1'b0;
        @(negedge clk);
        reg_rd(3'd4, d); chk("R10", "busy after foreign wake", d[4], 1'b1);
        chk("R10", "busy port", busy, 1'b1);
        reg_wr(3'd0, 8'h55);
        rd_count(v); chk("R11", "count write ignored while busy", v, 16'h0AAA);
        repeat (40) @(negedge clk);
        chk("R10", "busy clears after three ticks", busy, 1'b0);
        rd_count(v); chk("R11", "count unchanged after window", v, 16'h0AAA);
        reg_wr(3'd0, 8'h55);
        rd_count(v); chk("R2", "count write accepted after window", v, 16'h0A55);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_wrap;
        t_irq;
        t_low;
        t_hold;
        t_div12;
        t_slow;
        t_suspend_wake;
        t_busy;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule